// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block receives asynchronous serial characters by sampling the receive line many times per bit. A free-running divider on the reference clock produces a sample tick. With the default settings, a 3.6864 MHz reference divided by 24 gives sixteen samples per bit at 9600 baud. The line first passes through a two-flop synchronizer.

A high-to-low transition on the synchronized line, seen while the receiver is idle, opens a frame. The frame is a fixed sequence of sample words, one word per bit time. The first word covers the start bit. Eight words carry the data bits. Two words cover the stop bits.

Each word is reduced to a single bit by a majority vote over all of its samples. Mid-bit sampling is not used. The start word is discarded. The stop words are checked and then dropped. The data bits are assembled with the least significant bit first. When the last sample of the last stop word has been taken, the byte is presented with a one-cycle strobe and a framing-error flag.

Top module: `os_uart_rx`

## Requirements
- R1: The sample tick has a period of DIV reference-clock cycles. A bit time is OSR ticks (OSR × DIV cycles), and the frame's first tick comes DIV/2 cycles after the frame opens.
- R2: After reset, `valid_o`, `data_o` and `frame_err_o` are all 0.
- R3: An idle receiver that sees the synchronized line fall opens a frame of 1 + DATA_BITS + STOP_WORDS words of OSR samples each. The first word is the start word and contributes no data.
- R4: A data word votes 1 when more than half of its samples are 1, and 0 when fewer than half are 1.
- R5: A data word with exactly half of its samples at 1 votes 1.
- R6: The first data word after the start word becomes bit 0 of `data_o`, and each later data word the next higher bit.
- R7: `frame_err_o` is 1 when either stop word votes 0. The byte is still presented with its strobe.
- R8: Falling edges on the line while a frame is in progress do not open a new frame or shorten the current one.
- R9: `valid_o` is a single-cycle pulse, issued exactly once per frame, after the last sample of the last stop word.
- R10: Characters sent back to back with no idle time between them are each decoded correctly.
- R11: If the line is low at the end of a frame, no new frame opens until the line has been seen high and then falls again.
- R12: `data_o` and `frame_err_o` keep their values from one strobe to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| data_o | output | DATA_BITS | Last received byte, least significant bit from the first data word |
| valid_o | output | 1 | One-cycle strobe marking a new byte |
| frame_err_o | output | 1 | Set with the byte when a stop word voted 0 |

## Verification
Some properties are checked by assertions on every cycle:
- the tick never fires on two cycles in a row;
- an open frame stays open until its final sample;
- the strobe lasts one cycle and comes only as a frame closes;
- the outputs change only together with the strobe;
- an unarmed idle receiver stays idle.

Other behaviour can only be shown by the bench's scenarios:
- the vote outcome for clean words, split half-and-half words and glitched words;
- the bit order;
- the framing-error cases;
- frames sent back to back;
- a line held low after a bad stop word.

// File: rtl/os_uart_pkg.sv
package os_uart_pkg;

    typedef enum logic [1:0] {
        WR_START = 2'd0,
        WR_DATA  = 2'd1,
        WR_STOP  = 2'd2
    } word_role_e;

    // Role of a word from its index inside the frame.
    function automatic word_role_e role_of(input int unsigned idx,
                                           input int unsigned data_bits);
        if (idx == 0)
            return WR_START;
        else if (idx <= data_bits)
            return WR_DATA;
        else
            return WR_STOP;
    endfunction

endpackage

// File: rtl/os_tick_div.sv
module os_tick_div #(
    parameter int unsigned DIV = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i)
            cnt_d = HALF;
        else if (run_i)
            cnt_d = (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == TOP);

    // R1: ticks are DIV cycles apart, never on adjacent cycles
    p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/os_majority.sv
module os_majority #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             bit_o
);
    localparam int unsigned CNTW   = $clog2(WIDTH + 1);
    localparam logic [CNTW-1:0] THRESH = CNTW'(WIDTH - WIDTH / 2);

    logic [CNTW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < WIDTH; i++)
            ones = ones + CNTW'(word_i[i]);
    end

    // An even split reaches the threshold and resolves to 1.
    assign bit_o = (ones >= THRESH);

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
    import os_uart_pkg::*;
#(
    parameter int unsigned DIV        = 24,
    parameter int unsigned OSR        = 16,
    parameter int unsigned DATA_BITS  = 8,
    parameter int unsigned STOP_WORDS = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 frame_err_o
);
    localparam int unsigned FRAME_WORDS = 1 + DATA_BITS + STOP_WORDS;
    localparam int unsigned SW = $clog2(OSR);
    localparam int unsigned WW = $clog2(FRAME_WORDS);
    localparam logic [SW-1:0] SAMP_LAST = SW'(OSR - 1);
    localparam logic [WW-1:0] WORD_LAST = WW'(FRAME_WORDS - 1);

    typedef struct packed {
        logic [1:0]           sync;
        logic                 busy;
        logic                 armed;
        logic [SW-1:0]        samp;
        logic [WW-1:0]        word;
        logic [OSR-1:0]       win;
        logic [DATA_BITS-1:0] bits;
        logic                 err_acc;
        logic [DATA_BITS-1:0] data;
        logic                 ferr;
        logic                 valid;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic           rx_s;
    logic           open_frame;
    logic           tick;
    logic [OSR-1:0] win_next;
    logic           vote;
    logic           frame_done;
    word_role_e     role;

    assign rx_s       = st_q.sync[1];
    assign open_frame = !st_q.busy && st_q.armed && !rx_s;
    assign win_next   = {st_q.win[OSR-2:0], rx_s};
    assign role       = role_of(int'(st_q.word), DATA_BITS);
    assign frame_done = st_q.busy && tick && (st_q.samp == SAMP_LAST)
                        && (st_q.word == WORD_LAST);

    os_tick_div #(.DIV(DIV)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (open_frame),
        .run_i     (st_q.busy),
        .tick_o    (tick)
    );

    os_majority #(.WIDTH(OSR)) u_vote (
        .word_i (win_next),
        .bit_o  (vote)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = {st_q.sync[0], rx_i};
        if (!st_q.busy) begin
            st_d.armed = st_q.armed | rx_s;
            if (open_frame) begin
                st_d.busy    = 1'b1;
                st_d.armed   = 1'b0;
                st_d.samp    = '0;
                st_d.word    = '0;
                st_d.err_acc = 1'b0;
            end
        end else if (tick) begin
            st_d.win = win_next;
            if (st_q.samp == SAMP_LAST) begin
                st_d.samp = '0;
                case (role)
                    WR_DATA: st_d.bits    = {vote, st_q.bits[DATA_BITS-1:1]};
                    WR_STOP: st_d.err_acc = st_q.err_acc | !vote;
                    default: ;
                endcase
                if (st_q.word == WORD_LAST) begin
                    st_d.busy  = 1'b0;
                    st_d.valid = 1'b1;
                    st_d.data  = st_d.bits;
                    st_d.ferr  = st_d.err_acc;
                    // re-arm only if the line is still high at the end
                    st_d.armed = rx_s;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end else begin
                st_d.samp = st_q.samp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.sync <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o      = st_q.data;
    assign valid_o     = st_q.valid;
    assign frame_err_o = st_q.ferr;

    // R8: an open frame runs to its final sample
    p_frame_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !frame_done) |=> st_q.busy);

    // R9: strobe lasts one cycle
    p_strobe_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R9: strobe only as a frame closes
    p_strobe_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ($past(st_q.busy) && !st_q.busy));

    // R12: byte held between strobes
    p_data_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o) |-> valid_o);

    // R12: flag held between strobes
    p_ferr_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(frame_err_o) |-> valid_o);

    // R11: an unarmed idle receiver cannot open a frame
    p_no_rearm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.busy && !st_q.armed) |=> !st_q.busy);

endmodule

// File: tb/os_uart_rx_test.sv
module os_uart_rx_test;
    localparam int unsigned DIV = 8;
    localparam int unsigned OSR = 16;
    localparam int BIT = DIV * OSR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] data;
    logic       valid;
    logic       ferr;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int sent = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    os_uart_rx #(.DIV(DIV), .OSR(OSR), .DATA_BITS(8), .STOP_WORDS(2)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .rx_i        (rx),
        .data_o      (data),
        .valid_o     (valid),
        .frame_err_o (ferr)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Word kinds, as offsets within one bit time:
    //   0 = low; 1 = high;
    //   2 = high for the first half, low for the second (vote 1);
    //   3 = high for the first 5/16, then low (vote 0);
    //   4 = low for the first 5/16, then high (vote 1).
    task automatic drive_word(input int kind);
        for (int c = 0; c < BIT; c++) begin
            case (kind)
                0: rx = 1'b0;
                1: rx = 1'b1;
                2: rx = (c < BIT / 2);
                3: rx = (c < (BIT * 5) / 16);
                default: rx = !(c < (BIT * 5) / 16);
            endcase
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int k[11], input logic [7:0] ed,
                              input logic ef, input string tag);
        exp_q.push_back({ef, ed});
        tag_q.push_back(tag);
        sent++;
        for (int w = 0; w < 11; w++)
            drive_word(k[w]);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit s1, input bit s2,
                             input string tag);
        int k[11];
        k[0] = 0;
        for (int i = 0; i < 8; i++)
            k[i+1] = d[i] ? 1 : 0;
        k[9]  = s1 ? 1 : 0;
        k[10] = s2 ? 1 : 0;
        send_frame(k, d, !(s1 && s2), tag);
    endtask

    task automatic idle_bits(input int n);
        rx = 1'b1;
        repeat (n * BIT) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && valid) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected strobe", {23'd0, ferr, data}, 32'h0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({ferr, data} == e, t, {23'd0, ferr, data}, {23'd0, e});
            end
            @(negedge clk);
            check(!valid, "R9 strobe width", {31'd0, valid}, 32'd0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k[11];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(valid == 1'b0, "R2 valid", {31'd0, valid}, 32'd0);
        check(data == 8'h00, "R2 data", {24'd0, data}, 32'd0);
        check(ferr == 1'b0, "R2 ferr", {31'd0, ferr}, 32'd0);
        idle_bits(2);

        send_byte(8'hA5, 1, 1, "R3 R4 R6 byte A5");
        idle_bits(1);
        send_byte(8'h01, 1, 1, "R6 bit0 first");
        idle_bits(1);
        send_byte(8'h55, 1, 1, "R8 edges inside frame");
        idle_bits(1);
        send_byte(8'h00, 1, 1, "R4 all zero");
        send_byte(8'hFF, 1, 1, "R4 all one");
        idle_bits(1);

        // R1 R5: every data word split exactly in half -> ones
        k[0] = 0;
        for (int i = 1; i <= 8; i++) k[i] = 2;
        k[9] = 1; k[10] = 1;
        send_frame(k, 8'hFF, 1'b0, "R1 R5 tie votes 1");
        idle_bits(1);

        // R4 R8: glitched words; even bits kind 3 (0), odd kind 4 (1)
        k[0] = 0;
        for (int i = 0; i < 8; i++) k[i+1] = (i % 2 == 0) ? 3 : 4;
        k[9] = 1; k[10] = 1;
        send_frame(k, 8'hAA, 1'b0, "R4 R8 glitch majority");
        idle_bits(1);

        send_byte(8'h3C, 0, 1, "R7 first stop low");
        idle_bits(1);
        send_byte(8'hC3, 1, 0, "R7 second stop low");
        // R11: line stays low after the frame
        rx = 1'b0;
        repeat (3 * BIT) @(negedge clk);
        check(exp_q.size() == 0, "R11 pending after break", exp_q.size(), 32'd0);
        check(strobes == sent, "R11 no frame from low line", strobes, sent);
        idle_bits(1);
        check(data == 8'hC3, "R12 data held", {24'd0, data}, 32'hC3);
        check(ferr == 1'b1, "R12 ferr held", {31'd0, ferr}, 32'd1);
        send_byte(8'h81, 1, 1, "R11 recovers after high");

        // R10: back to back, no gap
        send_byte(8'h12, 1, 1, "R10 b2b 12");
        send_byte(8'h34, 1, 1, "R10 b2b 34");
        send_byte(8'h56, 1, 1, "R10 b2b 56");
        send_byte(8'h78, 1, 1, "R10 b2b 78");
        idle_bits(2);

        check(exp_q.size() == 0, "R9 all bytes delivered", exp_q.size(), 32'd0);
        check(strobes == sent, "R9 one strobe per frame", strobes, sent);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule